// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block lands incoming frames from a byte stream into host buffers that are managed through a small ring of receive descriptors. Each descriptor carries an ownership bit, a wrap bit, six error flags and a 16-bit length. The host hands a buffer to the engine by clearing its length and setting the ownership bit, then pulses the activate input. While armed and holding an engine-owned descriptor, the engine writes each byte of the next frame to that descriptor's buffer at increasing offsets. At the last byte it records the byte count and the error flags, returns the descriptor to the host and moves on to the next slot.

The engine enforces two limits. Bytes past the buffer limit are not stored. A frame longer than the frame limit is flagged. When the engine reaches a descriptor that the host still owns, it stops polling. Every frame that then arrives is discarded whole and counted in a saturating counter. Polling resumes only after the host returns buffers and writes the activate input again.

Buffer bytes leave on a registered write port as (slot, offset, byte). The host reads descriptors combinationally through a read port.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset every descriptor reads status 0 and length 0, the missed-frame count is 0, no buffer write is issued, and the engine is disarmed, so a frame that arrives is dropped.
- R2: The status word has bit 15 = engine owns (empty), bit 13 = wrap, bit 0 = the error input was high on some byte of the frame, bit 1 = frame too long. Bits 5:2 and all other bits read 0.
- R3: A host descriptor write sets the empty and wrap bits from its inputs and clears that descriptor's length and error flags.
- R4: A frame that starts while the engine is armed and the current descriptor is empty has its bytes issued on the write port one cycle after input, with that slot and offsets 0, 1, 2 and so on.
- R5: At the last byte of an accepted frame, the descriptor takes the received byte count as its length. Its empty bit clears and its wrap bit is kept.
- R6: Error flag bit 0 is set when the error input was high on any byte of the frame, including the last.
- R7: Only the first MAX_BUF (1520) bytes are written, and the recorded length is min(byte count, MAX_BUF).
- R8: Error flag bit 1 is set exactly when the byte count exceeds MAX_FRM (1518). A frame of exactly MAX_FRM bytes is not flagged.
- R9: After a frame the current slot advances by one. It returns to slot 0 after a descriptor whose wrap bit is set, and after slot NDESC-1 even without wrap.
- R10: When the engine is idle and the current descriptor is host-owned, it disarms. A later give-back without activate does not resume reception, and an activate pulse resumes it only if the current descriptor is then empty.
- R11: A frame that begins while not accepted is dropped whole, including bytes that come after a later activate. It is counted at its last byte in a 16-bit counter that holds at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe of the incoming stream |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_err | input | 1 | Receive error on this byte |
| rx_activate | input | 1 | Host pulse: refetch the current descriptor and resume polling |
| host_wr | input | 1 | Host descriptor write strobe |
| host_wr_slot | input | IDX_W | Descriptor being written |
| host_wr_empty | input | 1 | Value for the empty bit |
| host_wr_wrap | input | 1 | Value for the wrap bit |
| host_rd_slot | input | IDX_W | Descriptor being read |
| host_rd_status | output | 16 | Status word of the read descriptor |
| host_rd_len | output | 16 | Length field of the read descriptor |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_slot | output | IDX_W | Buffer (descriptor) index of the write |
| mem_off | output | OFF_W | Byte offset inside the buffer |
| mem_data | output | 8 | Byte written |
| missed_frames | output | MISS_W | Saturating count of dropped frames |

## Verification
Three frames from a stimulus table each land in their own slot: a clean 60-byte frame, a one-byte frame carrying an error, and a frame one byte over the frame limit that also closes the ring on a wrap bit. Together they separate the length, error and too-long paths and the wrap return. Directed frames of 1530 bytes and of exactly 1518 bytes then separate truncation from flagging, and a three-frame run over descriptors without wrap bits shows the natural return to slot 0 after the last slot. Frames sent after a give-back with no activate, and after an activate onto a host-owned slot, must be dropped and counted. A long run of one-byte frames drives the missed counter into saturation.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int STAT_EMPTY_BIT = 15;
  localparam int STAT_WRAP_BIT  = 13;
  localparam int ERR_W          = 6;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_DROP = 2'd2
  } fstate_t;

  function automatic logic [15:0] pack_status(input logic empty,
                                              input logic wrap,
                                              input logic [ERR_W-1:0] err);
    logic [15:0] s;
    s = '0;
    s[STAT_EMPTY_BIT] = empty;
    s[STAT_WRAP_BIT]  = wrap;
    s[ERR_W-1:0]      = err;
    return s;
  endfunction
endpackage

// File: rtl/rxr_desc_table.sv
module rxr_desc_table
  import rxr_pkg::*;
#(
  parameter int NDESC = 4,
  parameter int IDX_W = 2,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_slot,
  input  logic             host_empty,
  input  logic             host_wrap,
  input  logic             cmp_we,
  input  logic [IDX_W-1:0] cmp_slot,
  input  logic [LEN_W-1:0] cmp_len,
  input  logic [ERR_W-1:0] cmp_err,
  input  logic [IDX_W-1:0] rd_slot,
  output logic [15:0]      rd_status,
  output logic [LEN_W-1:0] rd_len,
  input  logic [IDX_W-1:0] cur_slot,
  output logic             cur_empty,
  output logic             cur_wrap
);
  logic             empty_q [NDESC];
  logic             wrap_q  [NDESC];
  logic [ERR_W-1:0] err_q   [NDESC];
  logic [LEN_W-1:0] len_q   [NDESC];

  for (genvar g = 0; g < NDESC; g++) begin : g_slot
    logic             en;
    logic             empty_n;
    logic             wrap_n;
    logic [ERR_W-1:0] err_n;
    logic [LEN_W-1:0] len_n;

    // engine completion wins over a host write to the same slot
    always_comb begin
      en      = 1'b0;
      empty_n = empty_q[g];
      wrap_n  = wrap_q[g];
      err_n   = err_q[g];
      len_n   = len_q[g];
      if (cmp_we && cmp_slot == IDX_W'(g)) begin
        en      = 1'b1;
        empty_n = 1'b0;
        err_n   = cmp_err;
        len_n   = cmp_len;
      end else if (host_we && host_slot == IDX_W'(g)) begin
        en      = 1'b1;
        empty_n = host_empty;
        wrap_n  = host_wrap;
        err_n   = '0;
        len_n   = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        empty_q[g] <= 1'b0;
        wrap_q[g]  <= 1'b0;
        err_q[g]   <= '0;
        len_q[g]   <= '0;
      end else if (en) begin
        empty_q[g] <= empty_n;
        wrap_q[g]  <= wrap_n;
        err_q[g]   <= err_n;
        len_q[g]   <= len_n;
      end
    end
  end

  always_comb begin
    rd_status = pack_status(empty_q[rd_slot], wrap_q[rd_slot], err_q[rd_slot]);
    rd_len    = len_q[rd_slot];
    cur_empty = empty_q[cur_slot];
    cur_wrap  = wrap_q[cur_slot];
  end
endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
  import rxr_pkg::*;
#(
  parameter int NDESC   = 4,
  parameter int IDX_W   = 2,
  parameter int OFF_W   = 11,
  parameter int LEN_W   = 16,
  parameter int MAX_BUF = 1520,
  parameter int MAX_FRM = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             rx_err,
  input  logic             rx_activate,
  input  logic             cur_empty,
  input  logic             cur_wrap,
  output logic [IDX_W-1:0] cur_slot,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_slot,
  output logic [OFF_W-1:0] mem_off,
  output logic [7:0]       mem_data,
  output logic             cmp_we,
  output logic [LEN_W-1:0] cmp_len,
  output logic [ERR_W-1:0] cmp_err,
  output logic             drop_done
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NDESC - 1);
  localparam logic [LEN_W-1:0] BUF_LIM   = LEN_W'(MAX_BUF);
  localparam logic [LEN_W-1:0] FRM_LIM   = LEN_W'(MAX_FRM);

  fstate_t          st_q, st_n;
  logic [IDX_W-1:0] cur_q, cur_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             err_q, err_n;
  logic             armed_q, armed_n;
  logic             mem_we_q;
  logic [IDX_W-1:0] mem_slot_q;
  logic [OFF_W-1:0] mem_off_q;
  logic [7:0]       mem_data_q;

  logic [LEN_W-1:0] base_cnt, total;
  logic             base_err, err_all;
  logic             accept, wr, finish;

  always_comb begin
    base_cnt = (st_q == FS_FILL) ? cnt_q : '0;
    base_err = (st_q == FS_FILL) & err_q;
    total    = (&base_cnt) ? base_cnt : base_cnt + 1'b1;
    err_all  = base_err | rx_err;
    accept   = armed_q & cur_empty;
  end

  always_comb begin
    st_n      = st_q;
    cur_n     = cur_q;
    cnt_n     = cnt_q;
    err_n     = err_q;
    wr        = 1'b0;
    finish    = 1'b0;
    drop_done = 1'b0;
    case (st_q)
      FS_IDLE: begin
        if (rx_valid) begin
          if (accept) begin
            wr = 1'b1;
            if (rx_last) begin
              finish = 1'b1;
            end else begin
              st_n  = FS_FILL;
              cnt_n = total;
              err_n = err_all;
            end
          end else if (rx_last) begin
            drop_done = 1'b1;
          end else begin
            st_n = FS_DROP;
          end
        end
      end
      FS_FILL: begin
        if (rx_valid) begin
          wr    = (base_cnt < BUF_LIM);
          cnt_n = total;
          err_n = err_all;
          if (rx_last) begin
            finish = 1'b1;
            st_n   = FS_IDLE;
          end
        end
      end
      FS_DROP: begin
        if (rx_valid && rx_last) begin
          drop_done = 1'b1;
          st_n      = FS_IDLE;
        end
      end
      default: st_n = FS_IDLE;
    endcase
    if (finish) begin
      cur_n = (cur_wrap || cur_q == LAST_SLOT) ? '0 : cur_q + 1'b1;
    end
    // stop polling on a host-owned descriptor; activate re-arms
    armed_n = rx_activate | (armed_q & ~((st_q == FS_IDLE) & ~cur_empty));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FS_IDLE;
      cur_q    <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      armed_q  <= 1'b0;
      mem_we_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      cur_q    <= cur_n;
      cnt_q    <= cnt_n;
      err_q    <= err_n;
      armed_q  <= armed_n;
      mem_we_q <= wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_slot_q <= '0;
      mem_off_q  <= '0;
      mem_data_q <= '0;
    end else if (wr) begin
      mem_slot_q <= cur_q;
      mem_off_q  <= base_cnt[OFF_W-1:0];
      mem_data_q <= rx_data;
    end
  end

  always_comb begin
    cur_slot = cur_q;
    mem_we   = mem_we_q;
    mem_slot = mem_slot_q;
    mem_off  = mem_off_q;
    mem_data = mem_data_q;
    cmp_we   = finish;
    cmp_len  = (total > BUF_LIM) ? BUF_LIM : total;
    cmp_err  = {{(ERR_W-2){1'b0}}, (total > FRM_LIM), err_all};
  end
endmodule

// File: rtl/rxr_miss_counter.sv
module rxr_miss_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         en;

  always_comb begin
    en    = inc & ~(&cnt_q);
    cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_n;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
  import rxr_pkg::*;
#(
  parameter int NDESC   = 4,
  parameter int MAX_BUF = 1520,
  parameter int MAX_FRM = 1518,
  parameter int MISS_W  = 16,
  parameter int IDX_W   = (NDESC > 1) ? $clog2(NDESC) : 1,
  parameter int OFF_W   = $clog2(MAX_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  input  logic              rx_activate,
  input  logic              host_wr,
  input  logic [IDX_W-1:0]  host_wr_slot,
  input  logic              host_wr_empty,
  input  logic              host_wr_wrap,
  input  logic [IDX_W-1:0]  host_rd_slot,
  output logic [15:0]       host_rd_status,
  output logic [15:0]       host_rd_len,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_slot,
  output logic [OFF_W-1:0]  mem_off,
  output logic [7:0]        mem_data,
  output logic [MISS_W-1:0] missed_frames
);
  localparam int LEN_W = 16;

  logic             rst_s1_q, rst_s2_q;
  logic             core_rst_n;
  logic [IDX_W-1:0] cur_slot;
  logic             cur_empty, cur_wrap;
  logic             cmp_we;
  logic [LEN_W-1:0] cmp_len;
  logic [ERR_W-1:0] cmp_err;
  logic             drop_done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign core_rst_n = rst_s2_q;

  rxr_desc_table #(.NDESC(NDESC), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_table (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .host_we   (host_wr),
    .host_slot (host_wr_slot),
    .host_empty(host_wr_empty),
    .host_wrap (host_wr_wrap),
    .cmp_we    (cmp_we),
    .cmp_slot  (cur_slot),
    .cmp_len   (cmp_len),
    .cmp_err   (cmp_err),
    .rd_slot   (host_rd_slot),
    .rd_status (host_rd_status),
    .rd_len    (host_rd_len),
    .cur_slot  (cur_slot),
    .cur_empty (cur_empty),
    .cur_wrap  (cur_wrap)
  );

  rxr_frame_ctl #(
    .NDESC(NDESC), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEN_W(LEN_W),
    .MAX_BUF(MAX_BUF), .MAX_FRM(MAX_FRM)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .rx_err     (rx_err),
    .rx_activate(rx_activate),
    .cur_empty  (cur_empty),
    .cur_wrap   (cur_wrap),
    .cur_slot   (cur_slot),
    .mem_we     (mem_we),
    .mem_slot   (mem_slot),
    .mem_off    (mem_off),
    .mem_data   (mem_data),
    .cmp_we     (cmp_we),
    .cmp_len    (cmp_len),
    .cmp_err    (cmp_err),
    .drop_done  (drop_done)
  );

  rxr_miss_counter #(.W(MISS_W)) u_miss (
    .clk  (clk),
    .rst_n(core_rst_n),
    .inc  (drop_done),
    .count(missed_frames)
  );
endmodule

// File: rtl/rxr_ring_engine_chk.sv
module rxr_ring_engine_chk #(
  parameter int MAX_BUF = 1520,
  parameter int MAX_FRM = 1518,
  parameter int MISS_W  = 16,
  parameter int IDX_W   = 2,
  parameter int OFF_W   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              mem_we,
  input logic [IDX_W-1:0]  mem_slot,
  input logic [OFF_W-1:0]  mem_off,
  input logic [MISS_W-1:0] missed_frames,
  input logic              cmp_we,
  input logic [15:0]       cmp_len,
  input logic [5:0]        cmp_err
);
  // R7: no write lands past the buffer
  p_off_in_buffer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_off) < MAX_BUF));

  // R4: a buffer write follows an input byte by one cycle
  p_write_follows_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rx_valid));

  // R4: offsets inside a frame step by one in the same slot
  p_off_sequential_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && mem_off != '0) |->
      (mem_off == $past(mem_off) + 1'b1 && mem_slot == $past(mem_slot)));

  // R11: the missed count moves by at most one per cycle and never falls
  p_missed_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (missed_frames == $past(missed_frames) ||
              missed_frames == $past(missed_frames) + 1'b1));

  // R2: unused error bits stay clear on completion
  p_cmp_err_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |-> (cmp_err[5:2] == 4'b0));

  // R7: recorded length never exceeds the buffer limit
  p_cmp_len_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |-> (int'(cmp_len) <= MAX_BUF && cmp_len != 16'd0));

  // R8: an unflagged frame is within the frame limit
  p_toolong_consistent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !cmp_err[1]) |-> (int'(cmp_len) <= MAX_FRM));
endmodule

bind rxr_ring_engine rxr_ring_engine_chk #(
  .MAX_BUF(MAX_BUF), .MAX_FRM(MAX_FRM), .MISS_W(MISS_W),
  .IDX_W(IDX_W), .OFF_W(OFF_W)
) u_chk (
  .clk          (clk),
  .rst_n        (core_rst_n),
  .rx_valid     (rx_valid),
  .mem_we       (mem_we),
  .mem_slot     (mem_slot),
  .mem_off      (mem_off),
  .missed_frames(missed_frames),
  .cmp_we       (cmp_we),
  .cmp_len      (cmp_len),
  .cmp_err      (cmp_err)
);

// File: tb/tb_rxr_ring_engine.sv
module tb_rxr_ring_engine;
  localparam int NDESC = 4, MAX_BUF = 1520, MAX_FRM = 1518, MISS_W = 16;
  localparam int IDX_W = 2, OFF_W = 11;

  logic clk, rst_n;
  logic rx_valid, rx_last, rx_err, rx_activate;
  logic [7:0] rx_data;
  logic host_wr, host_wr_empty, host_wr_wrap;
  logic [IDX_W-1:0] host_wr_slot, host_rd_slot;
  logic [15:0] host_rd_status, host_rd_len;
  logic mem_we;
  logic [IDX_W-1:0] mem_slot;
  logic [OFF_W-1:0] mem_off;
  logic [7:0] mem_data;
  logic [MISS_W-1:0] missed_frames;

  rxr_ring_engine #(.NDESC(NDESC), .MAX_BUF(MAX_BUF), .MAX_FRM(MAX_FRM), .MISS_W(MISS_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .rx_activate(rx_activate), .host_wr(host_wr), .host_wr_slot(host_wr_slot),
    .host_wr_empty(host_wr_empty), .host_wr_wrap(host_wr_wrap), .host_rd_slot(host_rd_slot),
    .host_rd_status(host_rd_status), .host_rd_len(host_rd_len), .mem_we(mem_we),
    .mem_slot(mem_slot), .mem_off(mem_off), .mem_data(mem_data), .missed_frames(missed_frames));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int w_cnt = 0, w_sum = 0, w_bad = 0, w_slot = 0;
  int exp_miss = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (mem_we) begin
      if (int'(mem_off) != w_cnt) w_bad = w_bad + 1;
      w_sum  = w_sum + int'(mem_data);
      w_slot = int'(mem_slot);
      w_cnt  = w_cnt + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_sum(input int len, input int seed);
    int s = 0;
    int n = (len > MAX_BUF) ? MAX_BUF : len;
    for (int i = 0; i < n; i++) s += (seed + i) & 255;
    return s;
  endfunction

  task automatic send_frame(input int len, input int errpos, input int seed);
    @(negedge clk);
    w_cnt = 0; w_sum = 0; w_bad = 0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'((seed + i) & 255);
      rx_last  = (i == len - 1);
      rx_err   = (i == errpos);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic give_back(input int slot, input bit wrap);
    @(negedge clk);
    host_wr = 1'b1; host_wr_slot = IDX_W'(slot); host_wr_empty = 1'b1; host_wr_wrap = wrap;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic activate();
    @(negedge clk);
    rx_activate = 1'b1;
    @(negedge clk);
    rx_activate = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_desc(input int slot, output int st, output int ln);
    host_rd_slot = IDX_W'(slot);
    #1;
    st = int'(host_rd_status);
    ln = int'(host_rd_len);
  endtask

  // len, error position, seed, slot, status, length
  localparam int VEC [3][6] = '{
    '{60,   -1, 5,  0, 16'h0000, 60},
    '{1,     0, 77, 1, 16'h0001, 1},
    '{1519, -1, 9,  2, 16'h2002, 1519}
  };

  initial begin
    int st, ln;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_err = 1'b0;
    rx_activate = 1'b0; host_wr = 1'b0; host_wr_slot = '0; host_wr_empty = 1'b0;
    host_wr_wrap = 1'b0; host_rd_slot = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int s = 0; s < NDESC; s++) begin
      read_desc(s, st, ln);
      check("R1", "reset status", st, 0);
      check("R1", "reset length", ln, 0);
    end
    check("R1", "reset missed", int'(missed_frames), 0);
    check("R1", "reset mem_we", int'(mem_we), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R11: disarmed after reset, frame dropped
    send_frame(8, -1, 1); exp_miss++;
    check("R1", "missed after frame while disarmed", int'(missed_frames), exp_miss);
    check("R1", "no writes while disarmed", w_cnt, 0);

    // R3: give back three slots, slot 2 closes the ring
    give_back(0, 0); give_back(1, 0); give_back(2, 1);
    read_desc(2, st, ln);
    check("R3", "give-back status", st, 16'hA000);
    activate();

    // R4 R5 R6 R8 R9: table of frames
    for (int v = 0; v < 3; v++) begin
      send_frame(VEC[v][0], VEC[v][1], VEC[v][2]);
      read_desc(VEC[v][3], st, ln);
      check("R5", $sformatf("vec%0d status", v), st, VEC[v][4]);
      check("R5", $sformatf("vec%0d length", v), ln, VEC[v][5]);
      check("R4", $sformatf("vec%0d write count", v), w_cnt, VEC[v][5]);
      check("R4", $sformatf("vec%0d byte sum", v), w_sum, exp_sum(VEC[v][0], VEC[v][2]));
      check("R4", $sformatf("vec%0d offsets", v), w_bad, 0);
      check("R9", $sformatf("vec%0d slot", v), w_slot, VEC[v][3]);
    end

    // R10: wrapped back to a host-owned slot 0, dropped
    send_frame(12, -1, 3); exp_miss++;
    check("R10", "drop on owned slot", int'(missed_frames), exp_miss);
    read_desc(0, st, ln);
    check("R10", "slot0 untouched", ln, 60);

    // R10: give-back without activate is ignored
    give_back(0, 0);
    send_frame(12, -1, 3); exp_miss++;
    check("R10", "drop without activate", int'(missed_frames), exp_miss);
    read_desc(0, st, ln);
    check("R10", "slot0 still empty status", st, 16'h8000);
    check("R10", "slot0 still zero length", ln, 0);

    // R7 R6 R8: truncation with an error mid-frame
    activate();
    send_frame(1530, 700, 200);
    read_desc(0, st, ln);
    check("R7", "truncated status", st, 16'h0003);
    check("R7", "truncated length", ln, MAX_BUF);
    check("R7", "truncated write count", w_cnt, MAX_BUF);
    check("R7", "truncated sum", w_sum, exp_sum(1530, 200));

    // R8: exactly the frame limit, not flagged
    give_back(1, 0);
    activate();
    send_frame(MAX_FRM, -1, 50);
    read_desc(1, st, ln);
    check("R8", "limit frame status", st, 16'h0000);
    check("R8", "limit frame length", ln, MAX_FRM);
    check("R9", "limit frame slot", w_slot, 1);

    // R9: natural wrap after the last slot without wrap bit
    give_back(2, 0); give_back(3, 0); give_back(0, 0);
    activate();
    send_frame(10, -1, 11);
    send_frame(20, -1, 12);
    read_desc(3, st, ln);
    check("R9", "slot3 length", ln, 20);
    send_frame(30, 29, 13);
    check("R9", "third frame slot", w_slot, 0);
    read_desc(0, st, ln);
    check("R9", "slot0 length after natural wrap", ln, 30);
    check("R6", "error on last byte", st, 16'h0001);

    // R10: activate onto a host-owned slot does not resume
    activate();
    send_frame(4, -1, 1); exp_miss++;
    check("R10", "activate on owned slot drops", int'(missed_frames), exp_miss);

    // R11: saturation of the missed counter
    @(negedge clk);
    rx_valid = 1'b1; rx_last = 1'b1;
    repeat (65540 - exp_miss) @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", "missed saturates", int'(missed_frames), 65535);
    read_desc(1, st, ln);
    check("R11", "slot1 untouched by drops", ln, MAX_FRM);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule